// File: doc/BRIEF.md
# SPI Serial Clock and Chip-Select Timing Generator

This block is the timing core of an SPI master. When the packet controller asks for a packet, it drives the chip-select and serial-clock pins. Chip select goes active and waits out a setup interval. The block then runs the requested number of bit periods, waits out a hold interval with chip select still active, and finally keeps chip select inactive for a minimum gap before it accepts the next packet. Each interval, and each of the two clock levels, lasts a programmed count plus one system-clock cycle.

The shift engine does not time anything itself. It receives a one-cycle launch strobe when it should present the next bit and a one-cycle capture strobe when it should sample the incoming bit. Both strobes follow the clock phase setting. A sample-select control moves the capture strobe one system cycle later.

The timing counts arrive as packed 32-bit configuration words. The parameter `ENHANCED` chooses how they are unpacked. When `ENHANCED` is 0, all four counts are 8-bit fields of one word. When it is 1, the counts are 16-bit fields split across two words. The gap count is always a separate 8-bit input.

Top module: `spi_sck_cs_timer`

## Requirements
- R1: After reset, and whenever no packet is in progress, `busy` is 0, `sck` equals `cpol`, `cs_out` is inactive (equal to `!cs_high`), and `launch` and `capture` are 0.
- R2: A `start` seen while idle makes `cs_out` active in the next cycle. Chip select then stays active with `sck` at its idle level for setup+1 cycles before the first clock edge.
- R3: The high level of `sck` lasts hi+1 cycles and the low level lasts lo+1 cycles. The level opposite to `cpol` comes first in each bit.
- R4: A packet has exactly `bit_cnt_m1`+1 bit periods. Each bit period is an active-level phase followed by an idle-level phase.
- R5: After the idle-level phase of the last bit, chip select stays active for hold+1 more cycles with `sck` at its idle level.
- R6: After chip select deasserts, `busy` stays 1 for `cs_idle_cnt`+1 cycles. A `start` that arrives while `busy` is 1 is ignored.
- R7: `sck` equals `cpol` whenever chip select is inactive.
- R8: `cs_high`=1 makes chip select active high and `cs_high`=0 makes it active low.
- R9: With `cpha`=0, `launch` pulses in the first setup cycle and in the cycle of each trailing edge except the last bit's. With `cpha`=1, `launch` pulses in the cycle of each leading edge. In both cases the packet has `bit_cnt_m1`+1 launches.
- R10: `capture` pulses in the cycle of each leading edge when `cpha`=0, and of each trailing edge when `cpha`=1. The cycle of an edge is the first cycle that `sck` shows the new level.
- R11: `sample_late`=1 delays every `capture` pulse by exactly one system cycle.
- R12: With `ENHANCED`=0, `timing_word0` holds hi at [7:0], lo at [15:8], hold at [23:16] and setup at [31:24]. With `ENHANCED`=1, `timing_word0` holds hi at [15:0] and lo at [31:16], and `timing_word1` holds hold at [15:0] and setup at [31:16].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| timing_word0 | input | 32 | Packed clock-level counts (and, in the 8-bit layout, CS counts) |
| timing_word1 | input | 32 | Packed CS setup and hold counts in the 16-bit layout |
| cs_idle_cnt | input | IDLE_W | Minimum chip-select gap between packets, minus one |
| cpol | input | 1 | Serial clock idle level |
| cpha | input | 1 | 0: capture on the leading edge; 1: capture on the trailing edge |
| cs_high | input | 1 | Chip-select active level |
| sample_late | input | 1 | Delay the capture strobe by one cycle |
| start | input | 1 | Request a packet (accepted only while idle) |
| bit_cnt_m1 | input | BITS_W | Bits in the packet, minus one |
| sck | output | 1 | Serial clock pin |
| cs_out | output | 1 | Chip-select pin |
| launch | output | 1 | Strobe to shift out the next bit |
| capture | output | 1 | Strobe to sample the incoming bit |
| busy | output | 1 | Packet or inter-packet gap in progress |

## Verification
The assertions assume that the configuration inputs (`timing_word0`, `timing_word1`, `cs_idle_cnt`, `cpol`, `cpha`, `cs_high`, `sample_late` and `bit_cnt_m1`) stay constant while `busy` is 1. They do not assume anything about when `start` arrives. The stimulus changes the configuration only after the reference queue has drained, which is at least one cycle after `busy` falls. It raises `start` deliberately during the gap to test that `start` is ignored while busy. Two instances, one per layout, receive the same counts packed in their own formats and must produce identical pin waveforms.

// File: rtl/spi_sck_cs_timer.sv
module spi_sck_cs_timer #(
  parameter bit ENHANCED = 1'b1,
  parameter int BITS_W   = 5,
  parameter int IDLE_W   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [31:0]       timing_word0,
  input  logic [31:0]       timing_word1,
  input  logic [IDLE_W-1:0] cs_idle_cnt,
  input  logic              cpol,
  input  logic              cpha,
  input  logic              cs_high,
  input  logic              sample_late,
  input  logic              start,
  input  logic [BITS_W-1:0] bit_cnt_m1,
  output logic              sck,
  output logic              cs_out,
  output logic              launch,
  output logic              capture,
  output logic              busy
);
  localparam int CW    = ENHANCED ? 16 : 8;
  localparam int CNT_W = (CW > IDLE_W) ? CW : IDLE_W;

  typedef enum logic [2:0] {T_IDLE, T_SETUP, T_ACT, T_REST, T_HOLD, T_GAP} tstate_e;

  tstate_e           st;
  logic [CNT_W-1:0]  cnt;
  logic [BITS_W-1:0] left;
  logic [CW-1:0]     hi_c, lo_c, setup_c, hold_c;
  logic              lead_q, trail_q, tlast_q, first_q, late_q;
  logic              cnt_zero, cap_now, cs_on;
  logic [CNT_W-1:0]  act_len, rest_len;

  generate
    if (ENHANCED) begin : g_wide
      assign hi_c    = timing_word0[15:0];
      assign lo_c    = timing_word0[31:16];
      assign hold_c  = timing_word1[15:0];
      assign setup_c = timing_word1[31:16];
    end else begin : g_narrow
      logic unused_word1;
      assign hi_c    = timing_word0[7:0];
      assign lo_c    = timing_word0[15:8];
      assign hold_c  = timing_word0[23:16];
      assign setup_c = timing_word0[31:24];
      assign unused_word1 = ^timing_word1;
    end
  endgenerate

  assign cnt_zero = (cnt == '0);
  assign act_len  = CNT_W'(cpol ? lo_c : hi_c);
  assign rest_len = CNT_W'(cpol ? hi_c : lo_c);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= T_IDLE;
      cnt     <= '0;
      left    <= '0;
      lead_q  <= 1'b0;
      trail_q <= 1'b0;
      tlast_q <= 1'b0;
      first_q <= 1'b0;
      late_q  <= 1'b0;
    end else begin
      lead_q  <= 1'b0;
      trail_q <= 1'b0;
      first_q <= 1'b0;
      late_q  <= cap_now;
      case (st)
        T_IDLE:
          if (start) begin
            st      <= T_SETUP;
            cnt     <= CNT_W'(setup_c);
            left    <= bit_cnt_m1;
            first_q <= 1'b1;
          end
        T_SETUP:
          if (cnt_zero) begin
            st     <= T_ACT;
            cnt    <= act_len;
            lead_q <= 1'b1;
          end else cnt <= cnt - 1'b1;
        T_ACT:
          if (cnt_zero) begin
            st      <= T_REST;
            cnt     <= rest_len;
            trail_q <= 1'b1;
            tlast_q <= (left == '0);
          end else cnt <= cnt - 1'b1;
        T_REST:
          if (cnt_zero) begin
            if (left == '0) begin
              st  <= T_HOLD;
              cnt <= CNT_W'(hold_c);
            end else begin
              st     <= T_ACT;
              cnt    <= act_len;
              left   <= left - 1'b1;
              lead_q <= 1'b1;
            end
          end else cnt <= cnt - 1'b1;
        T_HOLD:
          if (cnt_zero) begin
            st  <= T_GAP;
            cnt <= CNT_W'(cs_idle_cnt);
          end else cnt <= cnt - 1'b1;
        T_GAP:
          if (cnt_zero) st <= T_IDLE;
          else cnt <= cnt - 1'b1;
        default: st <= T_IDLE;
      endcase
    end
  end

  assign cap_now = cpha ? trail_q : lead_q;
  assign capture = sample_late ? late_q : cap_now;
  assign launch  = cpha ? lead_q : (first_q | (trail_q & ~tlast_q));
  assign cs_on   = (st == T_SETUP) || (st == T_ACT) || (st == T_REST) || (st == T_HOLD);
  assign cs_out  = cs_high ? cs_on : ~cs_on;
  assign sck     = cpol ^ (st == T_ACT);
  assign busy    = (st != T_IDLE);
endmodule

module spi_sck_cs_timer_chk (
  input logic clk,
  input logic rst_n,
  input logic cpol,
  input logic cs_high,
  input logic sck,
  input logic cs_out,
  input logic launch,
  input logic capture,
  input logic busy
);
  logic cs_on;
  assign cs_on = (cs_out == cs_high);

  // R7
  sck_idle_level_chk: assert property (@(posedge clk) disable iff (!rst_n) !cs_on |-> sck == cpol);
  // R1
  cs_inactive_idle_chk: assert property (@(posedge clk) disable iff (!rst_n) !busy |-> !cs_on);
  // R2
  setup_start_level_chk: assert property (@(posedge clk) disable iff (!rst_n) $rose(cs_on) |-> sck == cpol);
  // R6
  gap_follows_cs_chk: assert property (@(posedge clk) disable iff (!rst_n) $fell(cs_on) |-> busy);
  // R9
  launch_in_cs_chk: assert property (@(posedge clk) disable iff (!rst_n) launch |-> cs_on);
  // R10
  capture_busy_chk: assert property (@(posedge clk) disable iff (!rst_n) capture |-> busy);
endmodule

bind spi_sck_cs_timer spi_sck_cs_timer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cpol(cpol), .cs_high(cs_high), .sck(sck),
  .cs_out(cs_out), .launch(launch), .capture(capture), .busy(busy)
);

// File: tb/test_spi_sck_cs_timer.sv
module test_spi_sck_cs_timer;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [31:0] w0e = '0, w1e = '0, w0b = '0;
  logic [7:0]  idle_c = '0;
  logic cpol = 0, cpha = 0, csh = 0, late = 0, start = 0;
  logic [4:0] nb = '0;
  logic sck_e, cs_e, la_e, ca_e, bz_e;
  logic sck_b, cs_b, la_b, ca_b, bz_b;
  int checks = 0, errors = 0, cyc = 0;
  logic [4:0] exp_q[$];

  always #4 clk = ~clk;

  spi_sck_cs_timer #(.ENHANCED(1'b1)) i_spi_sck_cs_timer (
    .clk(clk), .rst_n(rst_n), .timing_word0(w0e), .timing_word1(w1e), .cs_idle_cnt(idle_c),
    .cpol(cpol), .cpha(cpha), .cs_high(csh), .sample_late(late), .start(start), .bit_cnt_m1(nb),
    .sck(sck_e), .cs_out(cs_e), .launch(la_e), .capture(ca_e), .busy(bz_e));

  spi_sck_cs_timer #(.ENHANCED(1'b0)) i_spi_sck_cs_timer_basic (
    .clk(clk), .rst_n(rst_n), .timing_word0(w0b), .timing_word1(32'hA5C3_3C5A), .cs_idle_cnt(idle_c),
    .cpol(cpol), .cpha(cpha), .cs_high(csh), .sample_late(late), .start(start), .bit_cnt_m1(nb),
    .sck(sck_b), .cs_out(cs_b), .launch(la_b), .capture(ca_b), .busy(bz_b));

  task automatic chk(string who, string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: got %0b expected %0b at cycle %0d", who, req, act, exp, cyc);
    end
  endtask

  // expected vector: {busy, cs_out, sck, launch, capture}
  always @(negedge clk) if (rst_n) begin
    logic [4:0] e;
    string tag;
    if (exp_q.size() != 0) begin e = exp_q.pop_front(); tag = ""; end
    else begin e = {1'b0, ~csh, cpol, 2'b00}; tag = " R1 idle"; end
    chk("wide", {"R6 busy", tag}, bz_e, e[4]);
    chk("wide", {"R2 R5 R8 cs", tag}, cs_e, e[3]);
    chk("wide", {"R3 R4 R7 sck", tag}, sck_e, e[2]);
    chk("wide", {"R9 launch", tag}, la_e, e[1]);
    chk("wide", {"R10 R11 capture", tag}, ca_e, e[0]);
    chk("narrow R12", "busy", bz_b, e[4]);
    chk("narrow R12", "cs", cs_b, e[3]);
    chk("narrow R12", "sck", sck_b, e[2]);
    chk("narrow R12", "launch", la_b, e[1]);
    chk("narrow R12", "capture", ca_b, e[0]);
  end

  task automatic run_packet(int hi, int lo, int su, int ho, int id,
                            bit p, bit h, bit ch, bit lt, int n, bit poke);
    int sckv[$], lead[$], trail[$], lastb[$], cson[$];
    int act, rst;
    bit prev_cap;
    @(posedge clk); #1;
    w0e = {lo[15:0], hi[15:0]};
    w1e = {su[15:0], ho[15:0]};
    w0b = {su[7:0], ho[7:0], lo[7:0], hi[7:0]};
    idle_c = id[7:0]; cpol = p; cpha = h; csh = ch; late = lt; nb = 5'(n - 1);
    act = p ? lo : hi;
    rst = p ? hi : lo;
    for (int i = 0; i <= su; i++) begin
      sckv.push_back(p); lead.push_back(0); trail.push_back(0); lastb.push_back(0); cson.push_back(1);
    end
    for (int b = 0; b < n; b++) begin
      for (int i = 0; i <= act; i++) begin
        sckv.push_back(!p); lead.push_back(i == 0); trail.push_back(0); lastb.push_back(0); cson.push_back(1);
      end
      for (int i = 0; i <= rst; i++) begin
        sckv.push_back(p); lead.push_back(0); trail.push_back(i == 0); lastb.push_back(b == n - 1); cson.push_back(1);
      end
    end
    for (int i = 0; i <= ho; i++) begin
      sckv.push_back(p); lead.push_back(0); trail.push_back(0); lastb.push_back(0); cson.push_back(1);
    end
    for (int i = 0; i <= id; i++) begin
      sckv.push_back(p); lead.push_back(0); trail.push_back(0); lastb.push_back(0); cson.push_back(0);
    end
    start = 1'b1;
    @(posedge clk); #1;
    start = 1'b0;
    prev_cap = 0;
    for (int i = 0; i < sckv.size(); i++) begin
      bit la, capn, cap, csp;
      la   = h ? lead[i] != 0 : ((i == 0) || (trail[i] != 0 && lastb[i] == 0));
      capn = h ? trail[i] != 0 : lead[i] != 0;
      cap  = lt ? prev_cap : capn;
      prev_cap = capn;
      csp  = (cson[i] != 0) ? ch : !ch;
      exp_q.push_back({1'b1, csp, sckv[i][0], la, cap});
    end
    if (poke) begin
      while (exp_q.size() != 2) begin @(negedge clk); #1; end
      @(posedge clk); #1; start = 1'b1;   // R6: ignored during gap
      @(posedge clk); #1; start = 1'b0;
    end
    while (exp_q.size() != 0) begin @(negedge clk); #1; end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog: got %0d cycles expected completion", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (2) @(negedge clk);
    #1;
    // R1 explicit reset state
    chk("wide", "R1 reset busy", bz_e, 1'b0);
    chk("wide", "R1 reset cs", cs_e, 1'b1);
    // R2 R3 R4 R5 R9 R10 basic mode 0
    run_packet(1, 2, 2, 1, 3, 0, 0, 0, 0, 4, 1);
    // R7 R8 R11 minimum counts, cpol 1, cpha 1, active-high CS, late sample
    run_packet(0, 0, 0, 0, 0, 1, 1, 1, 1, 3, 1);
    // single bit, asymmetric levels
    run_packet(3, 1, 1, 2, 1, 0, 1, 0, 0, 1, 0);
    // cpol 1 cpha 0 with late capture
    run_packet(2, 4, 3, 0, 2, 1, 0, 1, 1, 8, 0);
    // R11 zero active length with late capture in mode 0
    run_packet(0, 0, 1, 1, 1, 0, 0, 0, 1, 5, 0);
    // R12 upper field bits and full 32-bit packet
    run_packet(20, 5, 30, 10, 255, 0, 1, 1, 0, 32, 1);
    repeat (4) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule